// File: doc/BRIEF.md
# Array Edge Link Concentrator

This block sits on one side of a two-dimensional core array. It joins the boundary links of every row on that side to a single shared word link that leaves the chip. Each side of the array has its own instance. The block works in two independent directions.

In the outbound direction, rows that have a packet to send present it on their own valid/ready port. A round-robin arbiter picks one row per free slot. The block puts the row's index in front of the payload and places the word in a one-entry output register that drives the shared link. In the inbound direction, a word arriving from the shared link is caught in a one-entry holding stage. The block reads the row index from the word's top bits, strips it off, and offers the payload to that row only.

A neighbouring chip that uses the same block on its facing side can therefore rebuild the row position of every packet, with no extra logic between the two chips. The row count and the payload width are parameters. The tag width is the bit count needed to number the rows, with a minimum of one bit.

Every stream port follows the same valid/ready rule. A word passes on a clock edge where valid and ready are both high. A sender that has raised valid keeps valid high and its data unchanged until that transfer happens. Ready may depend on the other side's valid in the same cycle.

Top module: `edge_link_merge_split`

## Requirements
- R1: After reset is released, `tx_valid`, every bit of `ingr_valid` and `bad_tag` are low, and `rx_ready` is high.
- R2: A word on `tx_data` carries the source row index in bits [LINK_W-1:PAY_W] and that row's payload, unchanged, in bits [PAY_W-1:0]. LINK_W is PAY_W plus the tag width.
- R3: Outbound arbitration is round-robin. After row r is accepted, the search for the next grant starts at row r+1 and wraps to row 0 after the last row. `egr_ready` has at most one bit set. A row that keeps `egr_valid` high is accepted before ROWS other grants have gone to other rows.
- R4: A row is accepted only when the output register is empty or is being emptied in that cycle. An accepted word appears on `tx_valid`/`tx_data` on the next cycle. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds steady and no row is accepted.
- R5: A word accepted on the shared inbound link appears on the next cycle as `ingr_valid[t]` with its payload on `ingr_data` row t, where t is the word's top tag bits. No other row's valid is set.
- R6: If the target row does not take the word, the holding stage keeps it, `rx_ready` stays low, and no other row receives anything until that row takes it.
- R7: A word whose tag is ROWS or greater raises `bad_tag` for exactly one cycle. No row is offered the word, it is discarded in that cycle, and `rx_ready` is high in that cycle.
- R8: Within each row, packet order is preserved in both directions, and no packet is lost or duplicated.
- R9: The two directions are independent. Back-pressure on the outbound link does not slow the inbound path, and the reverse also holds.
- R10: With no back-pressure, each direction moves one word per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| egr_valid | input | ROWS | Per-row outbound packet present |
| egr_data | input | ROWS*PAY_W | Per-row outbound payloads; row i in bits [i*PAY_W +: PAY_W] |
| egr_ready | output | ROWS | Per-row outbound accept |
| tx_valid | output | 1 | Shared outbound link word valid |
| tx_data | output | LINK_W | Shared outbound link word {tag, payload} |
| tx_ready | input | 1 | Shared outbound link accepts word |
| rx_valid | input | 1 | Shared inbound link word valid |
| rx_data | input | LINK_W | Shared inbound link word {tag, payload} |
| rx_ready | output | 1 | Block accepts inbound word |
| ingr_valid | output | ROWS | Per-row inbound payload present |
| ingr_data | output | ROWS*PAY_W | Per-row inbound payloads; row i in bits [i*PAY_W +: PAY_W] |
| ingr_ready | input | ROWS | Per-row inbound accept |
| bad_tag | output | 1 | Pulses when a word with an out-of-range tag is discarded |

## Verification
The hardest case to reach from the ports is a single inbound row held not-ready while most arriving words target that row. In this case the stall must spread back to the shared link and hold off every other row, yet it must not disturb the outbound direction. The stimulus reaches it with a phase that keeps one row's ready low and aims about half of the inbound tags at that row, while outbound traffic keeps running. A second hard case is fairness under full load, where every row requests on every cycle. A phase with all rows valid and the link always ready checks that each row gets an equal share of grants.

// File: rtl/edge_link_pkg.sv
package edge_link_pkg;

  // Bits needed to number n rows; never less than one.
  function automatic int tag_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          any,
  output logic [IW-1:0] gnt_idx,
  output logic [N-1:0]  gnt_oh
);

  logic [IW-1:0] ptr_q;

  always_comb begin
    int idx;
    gnt_idx = '0;
    any     = |req;
    // Scan from the farthest offset down, so the nearest requester wins.
    for (int off = N - 1; off >= 0; off--) begin
      idx = (int'(ptr_q) + off) % N;
      if (req[idx]) gnt_idx = IW'(idx);
    end
    gnt_oh = any ? (N'(1) << gnt_idx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv && any) begin
      ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
    end
  end

endmodule

// File: rtl/merge_lane.sv
module merge_lane #(
  parameter int ROWS  = 6,
  parameter int PAY_W = 12,
  parameter int TAG_W = 3,
  localparam int LINK_W = TAG_W + PAY_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROWS-1:0]       egr_valid,
  input  logic [ROWS*PAY_W-1:0] egr_data,
  output logic [ROWS-1:0]       egr_ready,
  output logic                  tx_valid,
  output logic [LINK_W-1:0]     tx_data,
  input  logic                  tx_ready
);

  logic              load;
  logic              any;
  logic [TAG_W-1:0]  gnt_idx;
  logic [ROWS-1:0]   gnt_oh;
  logic [PAY_W-1:0]  sel_pay;
  logic              out_v_q;
  logic [LINK_W-1:0] out_d_q;

  // The output slot can take a new word when it is empty or draining now.
  assign load = !out_v_q || tx_ready;

  rr_pick #(.N(ROWS), .IW(TAG_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (egr_valid),
    .adv     (load),
    .any     (any),
    .gnt_idx (gnt_idx),
    .gnt_oh  (gnt_oh)
  );

  assign egr_ready = load ? gnt_oh : '0;
  assign sel_pay   = egr_data[int'(gnt_idx)*PAY_W +: PAY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else if (load) begin
      out_v_q <= any;
      if (any) out_d_q <= {gnt_idx, sel_pay};
    end
  end

  assign tx_valid = out_v_q;
  assign tx_data  = out_d_q;

endmodule

// File: rtl/split_lane.sv
module split_lane #(
  parameter int ROWS  = 6,
  parameter int PAY_W = 12,
  parameter int TAG_W = 3,
  localparam int LINK_W = TAG_W + PAY_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [LINK_W-1:0]     rx_data,
  output logic                  rx_ready,
  output logic [ROWS-1:0]       ingr_valid,
  output logic [ROWS*PAY_W-1:0] ingr_data,
  input  logic [ROWS-1:0]       ingr_ready,
  output logic                  bad_tag
);

  logic              hold_v_q;
  logic [LINK_W-1:0] hold_d_q;
  logic [TAG_W-1:0]  tag;
  logic              tag_ok;
  logic              consumed;

  assign tag    = hold_d_q[LINK_W-1 -: TAG_W];
  assign tag_ok = {1'b0, tag} < (TAG_W+1)'(ROWS);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign ingr_valid[i]                 = hold_v_q && tag_ok && (tag == TAG_W'(i));
    assign ingr_data[i*PAY_W +: PAY_W]   = hold_d_q[PAY_W-1:0];
  end

  // A bad word leaves at once; a good one leaves when its row takes it.
  assign consumed = hold_v_q && (!tag_ok || |(ingr_valid & ingr_ready));
  assign rx_ready = !hold_v_q || consumed;
  assign bad_tag  = hold_v_q && !tag_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else if (rx_ready) begin
      hold_v_q <= rx_valid;
      if (rx_valid) hold_d_q <= rx_data;
    end
  end

endmodule

// File: rtl/edge_link_merge_split.sv
module edge_link_merge_split #(
  parameter int ROWS  = 6,
  parameter int PAY_W = 12,
  localparam int TAG_W  = edge_link_pkg::tag_bits(ROWS),
  localparam int LINK_W = TAG_W + PAY_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROWS-1:0]       egr_valid,
  input  logic [ROWS*PAY_W-1:0] egr_data,
  output logic [ROWS-1:0]       egr_ready,
  output logic                  tx_valid,
  output logic [LINK_W-1:0]     tx_data,
  input  logic                  tx_ready,
  input  logic                  rx_valid,
  input  logic [LINK_W-1:0]     rx_data,
  output logic                  rx_ready,
  output logic [ROWS-1:0]       ingr_valid,
  output logic [ROWS*PAY_W-1:0] ingr_data,
  input  logic [ROWS-1:0]       ingr_ready,
  output logic                  bad_tag
);

  merge_lane #(.ROWS(ROWS), .PAY_W(PAY_W), .TAG_W(TAG_W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .egr_valid (egr_valid),
    .egr_data  (egr_data),
    .egr_ready (egr_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );

  split_lane #(.ROWS(ROWS), .PAY_W(PAY_W), .TAG_W(TAG_W)) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .ingr_valid (ingr_valid),
    .ingr_data  (ingr_data),
    .ingr_ready (ingr_ready),
    .bad_tag    (bad_tag)
  );

endmodule

// File: rtl/edge_link_chk.sv
module edge_link_chk #(
  parameter int ROWS  = 6,
  parameter int PAY_W = 12,
  localparam int TAG_W  = edge_link_pkg::tag_bits(ROWS),
  localparam int LINK_W = TAG_W + PAY_W,
  localparam int CW     = $clog2(ROWS + 1) + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ROWS-1:0]       egr_valid,
  input logic [ROWS*PAY_W-1:0] egr_data,
  input logic [ROWS-1:0]       egr_ready,
  input logic                  tx_valid,
  input logic [LINK_W-1:0]     tx_data,
  input logic                  tx_ready,
  input logic                  rx_valid,
  input logic [LINK_W-1:0]     rx_data,
  input logic                  rx_ready,
  input logic [ROWS-1:0]       ingr_valid,
  input logic [ROWS*PAY_W-1:0] ingr_data,
  input logic [ROWS-1:0]       ingr_ready,
  input logic                  bad_tag
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_valid && ingr_valid == '0 && !bad_tag && rx_ready));

  p_tag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ({1'b0, tx_data[LINK_W-1 -: TAG_W]} < (TAG_W+1)'(ROWS)));

  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(egr_ready));

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_no_accept_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |-> (egr_ready == '0));

  p_one_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ingr_valid));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ingr_valid & ~ingr_ready)) |=> ($stable(ingr_valid) && $stable(ingr_data)));

  p_stall_backpress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ingr_valid & ~ingr_ready)) |-> !rx_ready);

  p_bad_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_tag |-> (ingr_valid == '0 && rx_ready));

  // R3: count grants to other rows while a row waits with valid held.
  for (genvar i = 0; i < ROWS; i++) begin : g_fair
    logic [CW-1:0] wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= '0;
      else if (!egr_valid[i] || egr_ready[i]) wait_q <= '0;
      else if (|egr_ready) wait_q <= wait_q + CW'(1);
    end
    p_fair_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q < CW'(ROWS));
  end

endmodule

bind edge_link_merge_split edge_link_chk #(.ROWS(ROWS), .PAY_W(PAY_W)) u_chk (.*);

// File: tb/test_edge_link_merge_split.sv
module test_edge_link_merge_split;

  localparam int CLK_P  = 10;
  localparam int ROWS   = 6;
  localparam int PAY_W  = 12;
  localparam int TAG_W  = 3;
  localparam int LINK_W = TAG_W + PAY_W;
  localparam int WDOG   = 150000;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [ROWS-1:0]       egr_valid = '0;
  logic [ROWS*PAY_W-1:0] egr_data = '0;
  logic [ROWS-1:0]       egr_ready;
  logic                  tx_valid;
  logic [LINK_W-1:0]     tx_data;
  logic                  tx_ready = 1'b0;
  logic                  rx_valid = 1'b0;
  logic [LINK_W-1:0]     rx_data = '0;
  logic                  rx_ready;
  logic [ROWS-1:0]       ingr_valid;
  logic [ROWS*PAY_W-1:0] ingr_data;
  logic [ROWS-1:0]       ingr_ready = '0;
  logic                  bad_tag;

  edge_link_merge_split #(.ROWS(ROWS), .PAY_W(PAY_W)) i_edge_link_merge_split (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // stimulus knobs
  int p_egr = 50, p_txr = 70, p_rx = 60, p_ingr = 70, bad_pct = 10;
  int stall_row = -1, aim_row = -1;

  // reference model state
  bit               m_txv = 0;
  logic [LINK_W-1:0] m_txd = '0;
  int               m_ptr = 0;
  bit               m_hv = 0;
  logic [LINK_W-1:0] m_hd = '0;

  // scoreboards and phase counters
  logic [PAY_W-1:0] oq[ROWS][$];
  logic [PAY_W-1:0] iq[ROWS][$];
  int tx_hs = 0, rx_hs = 0, ingr_hs = 0, bad_seen = 0, bad_sent = 0;
  int row_tx[ROWS];
  bit took_e[ROWS];
  bit took_r = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL R10 watchdog: actual cycles %0d expected below %0d", cycles, WDOG);
      summary();
      $finish;
    end
  end

  task automatic step();
    bit load, any, ok, cons;
    int g, tag;
    logic [ROWS-1:0] e_er, e_iv;
    bit e_rxr, e_bad;
    @(negedge clk);
    // sources: keep valid and data until taken
    for (int i = 0; i < ROWS; i++) begin
      if (!egr_valid[i] || took_e[i]) begin
        egr_valid[i] = (($urandom % 100) < p_egr);
        egr_data[i*PAY_W +: PAY_W] = PAY_W'($urandom);
      end
      ingr_ready[i] = (($urandom % 100) < p_ingr) && (i != stall_row);
    end
    if (!rx_valid || took_r) begin
      rx_valid = (($urandom % 100) < p_rx);
      if (($urandom % 100) < bad_pct) tag = ROWS + int'($urandom % ((1 << TAG_W) - ROWS));
      else if (aim_row >= 0 && $urandom % 2 == 0) tag = aim_row;
      else tag = int'($urandom % ROWS);
      rx_data = {TAG_W'(tag), PAY_W'($urandom)};
    end
    tx_ready = (($urandom % 100) < p_txr);
    #1;
    // expected outputs from model
    load = !m_txv || tx_ready;
    any = 0; g = 0;
    for (int off = ROWS - 1; off >= 0; off--) begin
      int idx;
      idx = (m_ptr + off) % ROWS;
      if (egr_valid[idx]) begin any = 1; g = idx; end
    end
    e_er  = (load && any) ? ROWS'(1) << g : '0;
    tag   = int'(m_hd[LINK_W-1 -: TAG_W]);
    ok    = tag < ROWS;
    e_iv  = (m_hv && ok) ? ROWS'(1) << tag : '0;
    e_bad = m_hv && !ok;
    cons  = m_hv && (!ok || ingr_ready[tag]);
    e_rxr = !m_hv || cons;
    chk(egr_ready == e_er, "R3", "egr_ready", 64'(egr_ready), 64'(e_er));
    chk(tx_valid == m_txv, "R4", "tx_valid", 64'(tx_valid), 64'(m_txv));
    if (m_txv) chk(tx_data == m_txd, "R2", "tx_data", 64'(tx_data), 64'(m_txd));
    chk(rx_ready == e_rxr, "R6", "rx_ready", 64'(rx_ready), 64'(e_rxr));
    chk(ingr_valid == e_iv, "R5", "ingr_valid", 64'(ingr_valid), 64'(e_iv));
    if (m_hv && ok)
      chk(ingr_data[tag*PAY_W +: PAY_W] == m_hd[PAY_W-1:0], "R5", "ingr_data",
          64'(ingr_data[tag*PAY_W +: PAY_W]), 64'(m_hd[PAY_W-1:0]));
    chk(bad_tag == e_bad, "R7", "bad_tag", 64'(bad_tag), 64'(e_bad));
    // scoreboards, from observed handshakes
    for (int i = 0; i < ROWS; i++) begin
      took_e[i] = egr_valid[i] && egr_ready[i];
      if (took_e[i]) oq[i].push_back(egr_data[i*PAY_W +: PAY_W]);
      if (ingr_valid[i] && ingr_ready[i]) begin
        ingr_hs++;
        if (iq[i].size() == 0) chk(0, "R8", "ingress extra word", 64'(i), 64'(0));
        else begin
          logic [PAY_W-1:0] w;
          w = iq[i].pop_front();
          chk(ingr_data[i*PAY_W +: PAY_W] == w, "R8", "ingress order",
              64'(ingr_data[i*PAY_W +: PAY_W]), 64'(w));
        end
      end
    end
    if (tx_valid && tx_ready) begin
      int r;
      r = int'(tx_data[LINK_W-1 -: TAG_W]);
      tx_hs++;
      if (r < ROWS) begin
        row_tx[r]++;
        if (oq[r].size() == 0) chk(0, "R8", "egress extra word", 64'(r), 64'(0));
        else begin
          logic [PAY_W-1:0] w;
          w = oq[r].pop_front();
          chk(tx_data[PAY_W-1:0] == w, "R8", "egress order", 64'(tx_data[PAY_W-1:0]), 64'(w));
        end
      end
    end
    took_r = rx_valid && rx_ready;
    if (took_r) begin
      rx_hs++;
      if (int'(rx_data[LINK_W-1 -: TAG_W]) < ROWS)
        iq[int'(rx_data[LINK_W-1 -: TAG_W])].push_back(rx_data[PAY_W-1:0]);
      else bad_sent++;
    end
    if (bad_tag) bad_seen++;
    // advance model
    if (load) begin
      m_txv = any;
      if (any) begin
        m_txd = {TAG_W'(g), egr_data[g*PAY_W +: PAY_W]};
        m_ptr = (g + 1) % ROWS;
      end
    end
    if (e_rxr) begin
      m_hv = rx_valid;
      if (rx_valid) m_hd = rx_data;
    end
  endtask

  task automatic clear_counts();
    tx_hs = 0; rx_hs = 0; ingr_hs = 0;
    for (int i = 0; i < ROWS; i++) row_tx[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < ROWS; i++) begin took_e[i] = 0; row_tx[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle state right after reset release
    chk(tx_valid == 1'b0, "R1", "tx_valid after reset", 64'(tx_valid), 64'(0));
    chk(ingr_valid == '0, "R1", "ingr_valid after reset", 64'(ingr_valid), 64'(0));
    chk(bad_tag == 1'b0, "R1", "bad_tag after reset", 64'(bad_tag), 64'(0));
    chk(rx_ready == 1'b1, "R1", "rx_ready after reset", 64'(rx_ready), 64'(1));

    // mixed random traffic
    repeat (2000) step();

    // R3: full load, equal shares
    p_egr = 100; p_txr = 100; bad_pct = 0;
    repeat (4) step();
    clear_counts();
    repeat (60) step();
    for (int i = 0; i < ROWS; i++)
      chk(row_tx[i] >= 9 && row_tx[i] <= 11, "R3", "grants per row in 60 cycles",
          64'(row_tx[i]), 64'(10));

    // R9: outbound stalled, inbound at full rate
    p_txr = 0; p_rx = 100; p_ingr = 100;
    repeat (2) step();
    clear_counts();
    repeat (30) step();
    chk(tx_hs == 0, "R9", "outbound transfers while stalled", 64'(tx_hs), 64'(0));
    chk(rx_hs >= 29, "R9", "inbound transfers during outbound stall", 64'(rx_hs), 64'(30));

    // R6: one inbound row held off, traffic aimed at it
    p_txr = 70; p_egr = 60; stall_row = 2; aim_row = 2; p_ingr = 80;
    repeat (200) step();
    stall_row = -1; aim_row = -1;
    repeat (20) step();

    // R10: both directions unthrottled
    p_egr = 100; p_txr = 100; p_rx = 100; p_ingr = 100; bad_pct = 0;
    repeat (4) step();
    clear_counts();
    repeat (50) step();
    chk(tx_hs >= 49, "R10", "outbound words in 50 cycles", 64'(tx_hs), 64'(50));
    chk(rx_hs >= 49, "R10", "inbound words in 50 cycles", 64'(rx_hs), 64'(50));

    // more random traffic with heavier bad tags
    p_egr = 40; p_txr = 50; p_rx = 70; p_ingr = 50; bad_pct = 25;
    repeat (3000) step();

    // drain
    p_egr = 0; p_rx = 0; p_txr = 100; p_ingr = 100;
    repeat (30) step();
    for (int i = 0; i < ROWS; i++) begin
      chk(oq[i].size() == 0, "R8", "egress words left", 64'(oq[i].size()), 64'(0));
      chk(iq[i].size() == 0, "R8", "ingress words left", 64'(iq[i].size()), 64'(0));
    end
    chk(bad_seen == bad_sent, "R7", "bad_tag pulses vs bad words", 64'(bad_seen), 64'(bad_sent));
    chk(bad_sent > 0, "R7", "bad words exercised", 64'(bad_sent), 64'(1));

    done = 1;
    summary();
    $finish;
  end

endmodule